// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block produces the 16x oversampling tick that paces a serial transmitter and receiver, plus a bit-rate strobe that fires with every sixteenth tick. It counts cycles of a fast reference clock. Each tick period is an integer number of reference cycles, set by a 16-bit divisor. A 4-bit fraction, in sixteenths of a cycle, lengthens some ticks by one cycle. The average tick period can therefore fall between whole reference-cycle counts.

Software loads the divisor as floor(f_ref / (16 x baud)) - 1. It loads the fraction as the remainder of that division, times 16, truncated to 0..15. For example, a 100 MHz reference and a 115200 baud target give divisor 53 and fraction 4. The block applies new settings only at tick boundaries. A running stream of ticks therefore never contains a period built from two different settings.

Top module: `frac_baud_gen`

## Requirements
- R1: While `rst_n` is low or `en` is low, both outputs stay low, and the internal cycle and tick-slot counters return to zero. After `en` rises, or after `rst_n` is released with `en` high, the first tick comes in the cycle that completes one full period. That is, with D = divisor and s = stretch of slot 0, the tick comes in the (D+1+s)-th enabled cycle.
- R2: With fraction 0, every tick is spaced exactly D+1 reference cycles from the previous tick.
- R3: Over any aligned group of 16 ticks with a constant setting, the total length is 16(D+1)+F reference cycles, where F is the fraction.
- R4: Tick slots are numbered 0..15. Slot 0 is the first tick after enable or reset, and the numbering wraps. Slot k is stretched by one cycle exactly when floor((k+1)F/16) > floor(kF/16). This spreads the stretched ticks evenly across the group.
- R5: `bit_strobe` is high only together with `tick_16x`, and exactly on the tick of slot 15.
- R6: `tick_16x` is high for one reference cycle per tick period. With divisor 0 and fraction 0, the tick stays high on every enabled cycle.
- R7: A divisor or fraction change made partway through a period does not alter that period. It applies from the period that follows the next tick, and the slot numbering continues without restarting.
- R8: Divisor 0 with fraction 15 gives periods of 1 or 2 cycles, following the R4 pattern.
- R9: Divisor 53 with fraction 4 gives 16 ticks that total exactly 868 reference cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run enable; low clears the counters |
| div_int | input | 16 | Integer divisor D; tick period D+1 cycles |
| div_frac | input | 4 | Fraction F in sixteenths of a cycle |
| tick_16x | output | 1 | One-cycle tick at 16x the baud rate |
| bit_strobe | output | 1 | High with the tick of slot 15 |

## Verification
The checker keeps its own record of the divisor and fraction that were in force at the last tick boundary. It assumes the active setting is whatever the inputs held when the enable was low or when the previous tick fired, so inputs may move freely at any other time. The stimulus changes the settings only while the block is disabled, while it is in reset, or partway through a period, where R7 says the change is deferred. The spacing checks therefore always compare against the setting the design is actually running.

// File: rtl/baud_pkg.sv
// Package: shared widths for the fractional baud tick generator.
// Assumes the fraction is a binary count of sixteenths.
package baud_pkg;
    localparam int unsigned BG_DIV_W  = 16;   // integer divisor width
    localparam int unsigned BG_FRAC_W = 4;    // fraction width, 2**W slots per group
endpackage

// File: rtl/baud_frac_sel.sv
// Decides whether the current tick slot gets one extra reference cycle.
// Slot k of a 2**FRAC_W group is stretched when floor((k+1)F/2**W) exceeds
// floor(kF/2**W), which spreads F stretched slots evenly over the group.
// Assumes frac < 2**FRAC_W, so the two floors differ by at most one.
module baud_frac_sel #(
    parameter int unsigned FRAC_W = baud_pkg::BG_FRAC_W
) (
    input  logic [FRAC_W-1:0] slot,
    input  logic [FRAC_W-1:0] frac,
    output logic              stretch
);
    localparam int unsigned PW = 2 * FRAC_W + 1;

    logic [PW-1:0] prod_cur;
    logic [PW-1:0] prod_nxt;

    // Products for the current slot and the slot after it.
    always_comb begin
        prod_cur = PW'(slot) * PW'(frac);
        prod_nxt = (PW'(slot) + PW'(1)) * PW'(frac);
        stretch  = ((prod_nxt >> FRAC_W) != (prod_cur >> FRAC_W));
    end
endmodule

// File: rtl/baud_tick_cnt.sv
// Counts reference cycles within one tick period and flags the last cycle.
// Assumes limit is held stable by the caller for the whole period.
// Tick is high in the cycle where the count equals limit, giving limit+1
// cycles per period.
module baud_tick_cnt #(
    parameter int unsigned DIV_W = baud_pkg::BG_DIV_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic [DIV_W:0] limit,
    output logic           tick
);
    localparam int unsigned CW = DIV_W + 1;

    logic [CW-1:0] cnt;
    logic          run;

    // Counting is allowed only out of reset and while enabled.
    always_comb begin
        run  = en && rst_n;
        tick = run && (cnt == limit);
    end

    // Cycle counter: cleared when idle, wraps to zero on the tick.
    always_ff @(posedge clk) begin
        if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/baud_slot_cnt.sv
// Numbers ticks within a group of 2**FRAC_W and marks the final slot.
// Assumes tick is a one-cycle qualifier from the cycle counter.
module baud_slot_cnt #(
    parameter int unsigned FRAC_W = baud_pkg::BG_FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    output logic [FRAC_W-1:0] slot,
    output logic              last
);
    // Slot index: cleared when idle, advanced and wrapped on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            slot <= '0;
        end else if (tick) begin
            slot <= slot + FRAC_W'(1);
        end
    end

    // Final slot of the group.
    always_comb last = &slot;
endmodule

// File: rtl/frac_baud_gen.sv
// Fractional baud tick generator top.
// Produces a 16x oversampling tick from the reference clock using an
// integer divisor plus a fraction in sixteenths, and a bit strobe on the
// last tick of each group. Settings are captured while idle, in reset or
// on a tick, so a change made mid-period applies at the next boundary.
// Assumes rst_n is synchronous and active low.
module frac_baud_gen #(
    parameter int unsigned DIV_W  = baud_pkg::BG_DIV_W,
    parameter int unsigned FRAC_W = baud_pkg::BG_FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [DIV_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] div_frac,
    output logic              tick_16x,
    output logic              bit_strobe
);
    localparam int unsigned LW = DIV_W + 1;

    logic [DIV_W-1:0]  lat_div;
    logic [FRAC_W-1:0] lat_frac;
    logic [FRAC_W-1:0] slot;
    logic              slot_last;
    logic              stretch;
    logic              tick;
    logic [LW-1:0]     limit;

    // Setting capture: track inputs when idle, reload at each tick boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || tick) begin
            lat_div  <= div_int;
            lat_frac <= div_frac;
        end
    end

    baud_frac_sel #(.FRAC_W(FRAC_W)) frac_sel_i (
        .slot    (slot),
        .frac    (lat_frac),
        .stretch (stretch)
    );

    // Period limit: divisor plus the one-cycle stretch for this slot.
    always_comb limit = LW'(lat_div) + LW'(stretch);

    baud_tick_cnt #(.DIV_W(DIV_W)) tick_cnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .limit (limit),
        .tick  (tick)
    );

    baud_slot_cnt #(.FRAC_W(FRAC_W)) slot_cnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .tick  (tick),
        .slot  (slot),
        .last  (slot_last)
    );

    // Output drive.
    always_comb begin
        tick_16x   = tick;
        bit_strobe = tick && slot_last;
    end
endmodule

// File: rtl/frac_baud_gen_chk.sv
// Checker for the fractional baud tick generator, bound to the top.
// Keeps its own copy of the active setting and of the cycles since the
// last tick, and checks the tick spacing against them.
module frac_baud_gen_chk #(
    parameter int unsigned DIV_W  = baud_pkg::BG_DIV_W,
    parameter int unsigned FRAC_W = baud_pkg::BG_FRAC_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic [DIV_W-1:0]  div_int,
    input logic [FRAC_W-1:0] div_frac,
    input logic              tick_16x,
    input logic              bit_strobe
);
    logic [DIV_W:0]    gap;
    logic [DIV_W-1:0]  held_div;
    logic [FRAC_W-1:0] held_frac;

    // Observer state: setting in force and cycles elapsed in this period.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || tick_16x) begin
            held_div  <= div_int;
            held_frac <= div_frac;
            gap       <= '0;
        end else begin
            gap       <= gap + (DIV_W+1)'(1);
        end
    end

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!tick_16x && !bit_strobe));                           // R1
    AST_STROBE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        bit_strobe |-> tick_16x);                                      // R5
    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick_16x |-> (gap >= {1'b0, held_div} && gap <= {1'b0, held_div} + (DIV_W+1)'(1))); // R3
    AST_FRAC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_16x && held_frac == '0) |-> (gap == {1'b0, held_div}));  // R2
endmodule

bind frac_baud_gen frac_baud_gen_chk #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .div_int    (div_int),
    .div_frac   (div_frac),
    .tick_16x   (tick_16x),
    .bit_strobe (bit_strobe)
);

// File: tb/frac_baud_gen_tb_top.sv
// Scoreboard bench: driver pushes expected tick periods, monitor compares.
module frac_baud_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [15:0] div_in = '0;
    logic [3:0]  frac_in = '0;
    logic        tick;
    logic        strb;

    typedef struct {
        int    gap;
        bit    strb;
        int    grp;
        string tag;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    errors = 0;
    int    grp_acc = 0;

    always #5 clk = ~clk;

    frac_baud_gen dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .div_int    (div_in),
        .div_frac   (frac_in),
        .tick_16x   (tick),
        .bit_strobe (strb)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Model of the even spread: running remainder of F per slot.
    function automatic bit model_stretch(input int slot, input int f);
        int acc = 0;
        for (int j = 0; j < slot; j++) acc = (acc + f) % 16;
        return (acc + f) >= 16;
    endfunction

    task automatic push_seq(input int d, input int f, input int k0,
                            input int n, input string tag);
        for (int k = k0; k < k0 + n; k++) begin
            int    s;
            item_t it;
            s = k % 16;
            if (s == 0) grp_acc = 0;
            it.gap  = d + 1 + int'(model_stretch(s, f));
            grp_acc += it.gap;
            it.strb = (s == 15);
            it.grp  = it.strb ? ((tag == "R9") ? 868 : grp_acc) : 0;
            it.tag  = tag;
            q.push_back(it);
        end
    endtask

    task automatic drain();
        while (q.size() > 0) @(negedge clk);
    endtask

    task automatic run_case(input int d, input int f, input int n, input string tag);
        @(negedge clk);
        en = 1'b0; div_in = 16'(d); frac_in = 4'(f);
        @(negedge clk);
        q.delete();
        push_seq(d, f, 0, n, tag);
        en = 1'b1;
        drain();
        en = 1'b0;
    endtask

    // Monitor: counts enabled cycles between ticks and scores each tick.
    initial begin
        int    elapsed;
        int    gsum;
        item_t it;
        elapsed = 0;
        gsum = 0;
        forever begin
            @(negedge clk);
            #1;
            if (!(rst_n && en)) begin
                elapsed = 0;
                gsum = 0;
                chk(!tick && !strb, "R1", "output while idle", int'(tick | strb), 0);
            end else begin
                elapsed++;
                if (tick) begin
                    gsum += elapsed;
                    if (q.size() == 0) begin
                        chk(1'b0, "R6", "unexpected tick", elapsed, 0);
                    end else begin
                        it = q.pop_front();
                        chk(elapsed == it.gap, it.tag, "tick spacing", elapsed, it.gap);
                        chk(strb == it.strb, "R5", "strobe", int'(strb), int'(it.strb));
                        if (it.strb)
                            chk(gsum == it.grp, (it.tag == "R9") ? "R9" : "R3",
                                "group length", gsum, it.grp);
                    end
                    if (strb) gsum = 0;
                    elapsed = 0;
                end else begin
                    if (strb) chk(1'b0, "R5", "strobe without tick", 1, 0);
                    if (q.size() > 0 && elapsed >= q[0].gap) begin
                        chk(1'b0, q[0].tag, "missing tick", elapsed, q[0].gap);
                        void'(q.pop_front());
                        elapsed = 0;
                    end
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Driver.
    initial begin
        repeat (3) @(negedge clk);
        chk(tick == 1'b0, "R1", "tick in reset", int'(tick), 0);
        chk(strb == 1'b0, "R1", "strobe in reset", int'(strb), 0);
        @(negedge clk);
        rst_n = 1'b1;

        run_case(3, 0, 20, "R2");
        run_case(3, 5, 32, "R4");
        run_case(53, 4, 32, "R9");
        run_case(0, 15, 32, "R8");
        run_case(0, 0, 20, "R6");
        run_case(7, 11, 48, "R4");

        // R7: change the setting partway through the third period.
        @(negedge clk);
        en = 1'b0; div_in = 16'd9; frac_in = 4'd0;
        @(negedge clk);
        q.delete();
        push_seq(9, 0, 0, 3, "R7");
        en = 1'b1;
        while (q.size() > 1) @(negedge clk);
        repeat (3) @(negedge clk);
        div_in = 16'd4; frac_in = 4'd8;
        push_seq(4, 8, 3, 29, "R7");
        drain();
        en = 1'b0;

        // R1: disable partway, stay idle, then restart from slot 0.
        @(negedge clk);
        div_in = 16'd5; frac_in = 4'd3;
        @(negedge clk);
        q.delete();
        push_seq(5, 3, 0, 40, "R1");
        en = 1'b1;
        while (q.size() > 30) @(negedge clk);
        en = 1'b0;
        q.delete();
        repeat (4) @(negedge clk);
        run_case(5, 3, 20, "R1");

        // R1: reset while enabled, then a full period before the first tick.
        @(negedge clk);
        div_in = 16'd6; frac_in = 4'd9;
        @(negedge clk);
        q.delete();
        push_seq(6, 9, 0, 40, "R1");
        en = 1'b1;
        while (q.size() > 33) @(negedge clk);
        rst_n = 1'b0;
        q.delete();
        repeat (3) @(negedge clk);
        push_seq(6, 9, 0, 18, "R1");
        rst_n = 1'b1;
        drain();
        en = 1'b0;

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule